// File: doc/BRIEF.md
# Isochronous Receive Channel Filter Router

This block sits between a serial-bus link core and the receive queues. The link core delivers each received packet as a run of 32-bit quadlets, with the first one marked as the header. The block reads the header and sorts the packet into one of three kinds: self-ID, isochronous or asynchronous. Self-ID and asynchronous packets always go to the asynchronous receive queue. Isochronous packets are compared against a bank of eight programmable filter ports. Each port holds a channel number, a tag value and two enable bits. Port 0 is the only port that feeds the transport-stream receive queue. Ports 1 to 7 feed the isochronous receive queue. An isochronous packet that matches no port is discarded and counted.

The decision is taken on the header quadlet and registered. It leaves with the header on the forwarded beat one cycle later and stays fixed until the packet's last quadlet. A three-state machine controls this. IDLE waits for a header. FWD passes the beats of an accepted packet. DISCARD swallows the beats of a rejected packet.

The transitions are as follows. IDLE goes to FWD on an accepted multi-beat header. IDLE goes to DISCARD on a rejected multi-beat header. IDLE stays in IDLE on a single-beat header or on a stray beat. FWD goes back to IDLE on a valid last beat, and so does DISCARD.

Top module: `iso_rx_router`

## Requirements
- R1: After reset, `out_valid` is 0 and `drop_cnt` is 0.
- R2: In the header quadlet, the packet code is bits [7:4], the channel is bits [13:8] and the tag is bits [15:14]. Code 0xA means isochronous, code 0xE means self-ID, and any other code means asynchronous.
- R3: A self-ID packet is forwarded with `out_dest` = 1 (asynchronous queue) and `out_port` = 0.
- R4: An asynchronous packet is forwarded with `out_dest` = 1 and `out_port` = 0.
- R5: An isochronous packet won by port 0 is forwarded with `out_dest` = 3 (stream queue) and `out_port` = 0. No other port produces `out_dest` = 3.
- R6: An isochronous packet won by port 1 to 7 is forwarded with `out_dest` = 2 (isochronous queue), and `out_port` gives the port number.
- R7: Each port can filter in one of three ways. With only the channel enable set, it matches on the channel alone. With only the tag enable set, it matches on the tag alone. With both set, both fields must be equal.
- R8: A port with neither enable set matches no packet, whatever its channel and tag values are.
- R9: When several ports match, the lowest-numbered port wins.
- R10: Each beat of an accepted packet, from the header to the last beat, appears on `out_valid`/`out_data` exactly one cycle after it is input. The routing fields stay the same for the whole packet. Idle input cycles inside a packet produce no output.
- R11: An isochronous packet that matches no port produces no output beats, and `drop_cnt` increases by one in the cycle after its header.
- R12: A beat with `in_sop` low that arrives while no packet is open is ignored and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input quadlet is valid |
| in_sop | input | 1 | Input quadlet is the header |
| in_eop | input | 1 | Input quadlet is the last of the packet |
| in_data | input | 32 | Input quadlet |
| cfg_chan | input | 48 | Channel value per port, port p at [6p+5:6p] |
| cfg_tag | input | 16 | Tag value per port, port p at [2p+1:2p] |
| cfg_chan_en | input | 8 | Channel-match enable per port |
| cfg_tag_en | input | 8 | Tag-match enable per port |
| out_valid | output | 1 | Forwarded quadlet is valid |
| out_data | output | 32 | Forwarded quadlet |
| out_dest | output | 2 | Destination queue: 1 async, 2 iso, 3 stream |
| out_port | output | 3 | Winning filter port, 0 for non-isochronous packets |
| drop_cnt | output | 16 | Count of discarded isochronous packets, wraps |

## Verification
Every result the block produces is due exactly one clock edge after the input beat that causes it. This holds for the forwarded beat, its destination and port, and the drop count. The bench drives each beat on a falling edge. A behavioural model then works out what that beat must produce. On the next falling edge, before the following beat is driven, the bench compares all outputs with that prediction. The destination and port are compared only on cycles where a beat is expected. Every cycle also checks that no beat appears when none is due. This covers dropped packets, stray beats and idle cycles inside a packet.

// File: rtl/rx_route_pkg.sv
package rx_route_pkg;
    localparam int TCODE_W   = 4;
    localparam int TCODE_LSB = 4;
    localparam int CHAN_LSB  = 8;
    localparam logic [TCODE_W-1:0] TC_ISO    = 4'hA;
    localparam logic [TCODE_W-1:0] TC_SELFID = 4'hE;

    typedef enum logic [1:0] {
        DEST_NONE   = 2'd0,
        DEST_ASYNC  = 2'd1,
        DEST_ISO    = 2'd2,
        DEST_STREAM = 2'd3
    } dest_e;

    typedef enum logic [1:0] {
        RT_IDLE    = 2'd0,
        RT_FWD     = 2'd1,
        RT_DISCARD = 2'd2
    } rt_state_e;
endpackage

// File: rtl/iso_port_match.sv
module iso_port_match #(
    parameter int CHAN_W = 6,
    parameter int TAG_W  = 2
) (
    input  logic [CHAN_W-1:0] pkt_chan,
    input  logic [TAG_W-1:0]  pkt_tag,
    input  logic [CHAN_W-1:0] flt_chan,
    input  logic [TAG_W-1:0]  flt_tag,
    input  logic              flt_chan_en,
    input  logic              flt_tag_en,
    output logic              hit
);
    logic chan_ok;
    logic tag_ok;

    always_comb begin
        chan_ok = !flt_chan_en || (pkt_chan == flt_chan);
        tag_ok  = !flt_tag_en  || (pkt_tag  == flt_tag);
        // R8: at least one enable is required for any hit
        hit     = (flt_chan_en || flt_tag_en) && chan_ok && tag_ok;
    end
endmodule

// File: rtl/iso_port_pick.sv
module iso_port_pick #(
    parameter int NUM_PORTS = 8,
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] hits,
    output logic                 any_hit,
    output logic [PORT_W-1:0]    win_idx
);
    logic [NUM_PORTS-1:0] grant;

    always_comb begin
        grant   = '0;
        win_idx = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (hits[i]) begin
                grant   = '0;
                grant[i] = 1'b1;
                win_idx = PORT_W'(i);
            end
        end
        any_hit = |hits;
    end

    // R9: exactly one winner, and no hit below it
    p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ($onehot0(grant) && grant != '0));
    p_lowest_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> ((hits & (grant - 1'b1)) == '0));
endmodule

// File: rtl/iso_rx_router.sv
module iso_rx_router
    import rx_route_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int CHAN_W    = 6,
    parameter int TAG_W     = 2,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int TAG_LSB  = CHAN_LSB + CHAN_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_sop,
    input  logic                        in_eop,
    input  logic [DATA_W-1:0]           in_data,
    input  logic [NUM_PORTS*CHAN_W-1:0] cfg_chan,
    input  logic [NUM_PORTS*TAG_W-1:0]  cfg_tag,
    input  logic [NUM_PORTS-1:0]        cfg_chan_en,
    input  logic [NUM_PORTS-1:0]        cfg_tag_en,
    output logic                        out_valid,
    output logic [DATA_W-1:0]           out_data,
    output logic [1:0]                  out_dest,
    output logic [PORT_W-1:0]           out_port,
    output logic [CNT_W-1:0]            drop_cnt
);
    rt_state_e             state_q, state_d;
    logic [TCODE_W-1:0]    tcode;
    logic [CHAN_W-1:0]     pkt_chan;
    logic [TAG_W-1:0]      pkt_tag;
    logic [NUM_PORTS-1:0]  hits;
    logic                  any_hit;
    logic [PORT_W-1:0]     win_idx;
    logic                  is_iso;
    logic                  hdr_beat;
    logic                  hdr_keep;
    dest_e                 hdr_dest;
    logic [PORT_W-1:0]     hdr_port;
    dest_e                 dest_q;

    // R2: header field extraction
    assign tcode    = in_data[TCODE_LSB +: TCODE_W];
    assign pkt_chan = in_data[CHAN_LSB +: CHAN_W];
    assign pkt_tag  = in_data[TAG_LSB +: TAG_W];
    assign is_iso   = (tcode == TC_ISO);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        iso_port_match #(.CHAN_W(CHAN_W), .TAG_W(TAG_W)) i_match (
            .pkt_chan    (pkt_chan),
            .pkt_tag     (pkt_tag),
            .flt_chan    (cfg_chan[p*CHAN_W +: CHAN_W]),
            .flt_tag     (cfg_tag[p*TAG_W +: TAG_W]),
            .flt_chan_en (cfg_chan_en[p]),
            .flt_tag_en  (cfg_tag_en[p]),
            .hit         (hits[p])
        );
    end

    iso_port_pick #(.NUM_PORTS(NUM_PORTS)) i_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .hits    (hits),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    // Header classification (self-ID and async share the async queue)
    always_comb begin
        hdr_beat = (state_q == RT_IDLE) && in_valid && in_sop;
        hdr_port = '0;
        if (is_iso) begin
            hdr_keep = any_hit;
            hdr_port = win_idx;
            if (!any_hit)
                hdr_dest = DEST_NONE;
            else if (win_idx == '0)
                hdr_dest = DEST_STREAM;
            else
                hdr_dest = DEST_ISO;
        end else begin
            hdr_keep = 1'b1;
            hdr_dest = DEST_ASYNC;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RT_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RT_IDLE: begin
                if (hdr_beat && !in_eop)
                    state_d = hdr_keep ? RT_FWD : RT_DISCARD;
            end
            RT_FWD, RT_DISCARD: begin
                if (in_valid && in_eop)
                    state_d = RT_IDLE;
            end
            default: state_d = RT_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            dest_q    <= DEST_NONE;
            out_port  <= '0;
            drop_cnt  <= '0;
        end else begin
            out_valid <= (hdr_beat && hdr_keep) || (state_q == RT_FWD && in_valid);
            if (in_valid)
                out_data <= in_data;
            if (hdr_beat) begin
                dest_q   <= hdr_dest;
                out_port <= hdr_port;
            end
            if (hdr_beat && !hdr_keep)
                drop_cnt <= drop_cnt + CNT_W'(1);
        end
    end

    assign out_dest = dest_q;

    // R10: routing fields held while a packet is open
    p_route_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RT_IDLE) |=> ($stable(out_dest) && $stable(out_port)));
    // R5: stream queue only from port 0
    p_stream_port0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dest == DEST_STREAM) |-> (out_port == '0));
    // R6: iso queue only from ports 1..7
    p_iso_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dest == DEST_ISO) |-> (out_port != '0));
    // R11: discarded beats never emerge
    p_discard_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RT_DISCARD) |=> !out_valid);
    // R11: drop count steps by at most one
    p_drop_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drop_cnt) |-> (drop_cnt == $past(drop_cnt) + CNT_W'(1)));
    // R12: stray beat while idle is not forwarded
    p_stray_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RT_IDLE && in_valid && !in_sop) |=> !out_valid);
endmodule

// File: tb/test_iso_rx_router.sv
module test_iso_rx_router;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [31:0] in_data = '0;
    logic [47:0] cfg_chan = '0;
    logic [15:0] cfg_tag = '0;
    logic [7:0]  cfg_chan_en = '0, cfg_tag_en = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [1:0]  out_dest;
    logic [2:0]  out_port;
    logic [15:0] drop_cnt;

    int n_tests = 0, n_fail = 0;
    string cur_req = "R1";

    // behavioural model state
    bit          m_busy = 0, m_keep = 0;
    bit          exp_valid = 0;
    logic [31:0] exp_data = '0;
    int          exp_dest = 0, exp_port = 0, exp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iso_rx_router i_iso_rx_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .cfg_chan(cfg_chan),
        .cfg_tag(cfg_tag), .cfg_chan_en(cfg_chan_en), .cfg_tag_en(cfg_tag_en),
        .out_valid(out_valid), .out_data(out_data), .out_dest(out_dest),
        .out_port(out_port), .drop_cnt(drop_cnt)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr(logic [3:0] tc, logic [5:0] ch, logic [1:0] tg);
        return {16'h0010, tg, ch, tc, 4'h0};
    endfunction

    function automatic int find_port(logic [5:0] ch, logic [1:0] tg);
        for (int p = 0; p < NP; p++) begin
            bit ce = cfg_chan_en[p];
            bit te = cfg_tag_en[p];
            if ((ce || te) && (!ce || cfg_chan[p*6 +: 6] == ch) && (!te || cfg_tag[p*2 +: 2] == tg))
                return p;
        end
        return -1;
    endfunction

    task automatic set_port(int p, logic [5:0] ch, logic [1:0] tg, bit ce, bit te);
        cfg_chan[p*6 +: 6] = ch;
        cfg_tag[p*2 +: 2]  = tg;
        cfg_chan_en[p]     = ce;
        cfg_tag_en[p]      = te;
    endtask

    // compare outputs due from previous beat, then drive the next one
    task automatic beat(bit v, bit s, bit e, logic [31:0] d);
        @(negedge clk);
        check(out_valid == exp_valid, cur_req, "out_valid", out_valid, exp_valid);
        if (exp_valid) begin
            check(out_data == exp_data, cur_req, "out_data", out_data, exp_data);
            check(out_dest == 2'(exp_dest), cur_req, "out_dest", out_dest, exp_dest);
            check(out_port == 3'(exp_port), cur_req, "out_port", out_port, exp_port);
        end
        check(drop_cnt == 16'(exp_cnt), "R11", "drop_cnt", drop_cnt, exp_cnt);
        in_valid = v; in_sop = s; in_eop = e; in_data = d;
        if (!m_busy && v && s) begin
            if (d[7:4] == 4'hA) begin
                int p = find_port(d[13:8], d[15:14]);
                m_keep = (p >= 0);
                if (m_keep) begin
                    exp_dest = (p == 0) ? 3 : 2;
                    exp_port = p;
                end else begin
                    exp_cnt++;
                end
            end else begin
                m_keep = 1; exp_dest = 1; exp_port = 0;
            end
            exp_valid = m_keep;
            exp_data = d;
            m_busy = !e;
        end else if (m_busy && v) begin
            exp_valid = m_keep;
            exp_data = d;
            if (e) m_busy = 0;
        end else begin
            exp_valid = 0;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) beat(0, 0, 0, 32'h0);
    endtask

    task automatic packet(logic [31:0] h, int len);
        beat(1, 1, len == 1, h);
        for (int i = 1; i < len; i++) beat(1, 0, i == len - 1, h ^ (32'h1111_0000 * i));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        idle(2);

        cur_req = "R4";  packet(hdr(4'h1, 6'd0, 2'd0), 3);
        cur_req = "R3";  packet(hdr(4'hE, 6'd7, 2'd1), 2);
        idle(1);

        set_port(0, 6'd5, 2'd2, 1, 0);   // channel only
        set_port(1, 6'd0, 2'd2, 0, 1);   // tag only
        set_port(2, 6'd9, 2'd1, 1, 1);   // both
        set_port(3, 6'd20, 2'd0, 0, 0);  // disabled
        set_port(4, 6'd20, 2'd3, 1, 0);
        cur_req = "R5";  packet(hdr(4'hA, 6'd5, 2'd0), 3);
        cur_req = "R9";  packet(hdr(4'hA, 6'd5, 2'd2), 2);
        cur_req = "R7";  packet(hdr(4'hA, 6'd9, 2'd1), 2);
        cur_req = "R7";  packet(hdr(4'hA, 6'd30, 2'd2), 1);
        cur_req = "R8";  packet(hdr(4'hA, 6'd20, 2'd0), 2);
        cur_req = "R6";  packet(hdr(4'hA, 6'd9, 2'd2), 2);
        cur_req = "R11"; packet(hdr(4'hA, 6'd9, 2'd0), 3);
        cur_req = "R11"; packet(hdr(4'hA, 6'd33, 2'd3), 1);
        cur_req = "R12"; beat(1, 0, 0, 32'hDEAD_BEEF); beat(1, 0, 1, 32'hBEEF_0001);
        cur_req = "R10";
        beat(1, 1, 0, hdr(4'hA, 6'd20, 2'd1));
        beat(0, 0, 0, 32'h0);
        beat(1, 1, 0, hdr(4'h4, 6'd1, 2'd0));   // sop inside open packet: data beat
        beat(0, 0, 0, 32'h0);
        beat(1, 0, 1, 32'hCAFE_0003);
        cur_req = "R2";  packet(hdr(4'hB, 6'd5, 2'd0), 2);
        cur_req = "R11"; packet(hdr(4'hA, 6'd9, 2'd3), 2);
        idle(2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule